// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block keeps a wide up-counter that advances by one on every cycle in which the reference tick input is high, and makes its value readable through a 32-bit register port. Because a 32-bit bus cannot fetch a 64-bit value in one access, the two halves could otherwise come from different counts. To avoid this, software first writes a request bit in the control register. The block holds that bit at 1 for a fixed synchronisation delay. It then copies the live count into a frozen snapshot register and clears the bit in the same cycle.

Software polls the control register until the request bit reads 0. It then reads the upper half and the lower half of the snapshot. Both halves belong to the same instant and stay unchanged until the next request completes, while the live count keeps running underneath. The counter width is a parameter up to 64 bits; a narrower counter is zero-extended into the two halves.

Top module: `cnt_snap_top`

## Requirements
- R1: After a synchronous reset the live count and the snapshot are zero, and the control register reads 0.
- R2: The live count increases by exactly one on each clock edge where `ref_tick` is high and holds otherwise.
- R3: A write to offset 0xA0 with bit 1 set starts a snapshot request. From the next cycle the control register reads 0x2, and every control bit other than bit 1 always reads 0.
- R4: The request bit reads 1 for exactly `LATCH_DLY` consecutive cycles (default 3), then reads 0.
- R5: When the request bit clears, the snapshot holds the live count as it stood during the last cycle in which the bit read 1.
- R6: Offset 0xA8 returns snapshot bits 63:32 and offset 0xA4 returns bits 31:0. Both hold their value until the next request completes, however far the live count advances.
- R7: A further request written while one is pending is ignored: it neither lengthens nor restarts the delay.
- R8: The live count wraps from all ones to zero.
- R9: Writes to 0xA4 or 0xA8, and writes to 0xA0 with bit 1 clear, change neither the snapshot nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Count enable, one pulse per reference tick |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |

## Verification
The bench counts polled cycles with the request bit high. A design that cleared the bit a cycle early or late, or that restarted the delay on a second request, would show the wrong count. Each snapshot is compared with a tick model sampled in the last busy cycle. This catches a snapshot taken one edge too soon or too late, and halves that come from the live count instead of the frozen copy. Writes of random data to the half registers, and control writes with the request bit clear, must leave every readback unchanged. A second instance with an 8-bit counter runs past its all-ones value, so a counter that saturates or carries wrongly is caught.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int SNAP_W = 2 * BUS_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 8'hA8;

    localparam int LATCH_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LOW,
        SEL_HIGH
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] high;
        logic [BUS_W-1:0] low;
    } snap_halves_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_e s;
        unique case (ofs)
            OFS_CTRL: s = SEL_CTRL;
            OFS_LOW:  s = SEL_LOW;
            OFS_HIGH: s = SEL_HIGH;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic snap_halves_t split_snap(input logic [SNAP_W-1:0] v);
        snap_halves_t h;
        h.high = v[SNAP_W-1:BUS_W];
        h.low  = v[BUS_W-1:0];
        return h;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_word(input logic busy);
        logic [BUS_W-1:0] w;
        w = '0;
        w[LATCH_BIT] = busy;
        return w;
    endfunction

endpackage

// File: rtl/cnt_free_runner.sv
module cnt_free_runner #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == CNT_MAX) |=> cnt_q == '0); // R8

endmodule

// File: rtl/cnt_latch_ctl.sv
module cnt_latch_ctl
    import cnt_snap_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int LATCH_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic              busy,
    output logic [SNAP_W-1:0] snap
);

    localparam int DLY_W = $clog2(LATCH_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(LATCH_DLY);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(1);

    logic              busy_q;
    logic [DLY_W-1:0]  dly_q;
    logic [SNAP_W-1:0] snap_q;
    logic [SNAP_W-1:0] live_ext;

    generate
        if (CNT_W < SNAP_W) begin : g_pad
            assign live_ext = {{(SNAP_W-CNT_W){1'b0}}, live_cnt};
        end else begin : g_full
            assign live_ext = live_cnt[SNAP_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            dly_q  <= '0;
            snap_q <= '0;
        end else if (busy_q) begin
            dly_q <= dly_q - 1'b1;
            if (dly_q == DLY_LAST) begin
                busy_q <= 1'b0;
                snap_q <= live_ext;
            end
        end else if (req) begin
            busy_q <= 1'b1;
            dly_q  <= DLY_LOAD;
        end
    end

    assign busy = busy_q;
    assign snap = snap_q;

    AST_LATCH_START: assert property (@(posedge clk) disable iff (rst)
        (req && !busy_q) |=> busy_q); // R3
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> snap_q == $past(live_ext)); // R5
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy_q) |-> $stable(snap_q)); // R6
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && req) |=> (!busy_q || dly_q == DLY_W'($past(dly_q) - 1'b1))); // R7

endmodule

// File: rtl/cnt_reg_port.sv
module cnt_reg_port
    import cnt_snap_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic [SNAP_W-1:0] snap,
    output logic              latch_req,
    output logic [BUS_W-1:0]  bus_rdata
);

    reg_sel_e     sel;
    snap_halves_t halves;

    always_comb begin
        sel       = decode_ofs(bus_addr);
        halves    = split_snap(snap);
        latch_req = bus_wr && (sel == SEL_CTRL) && bus_wdata[LATCH_BIT];
        unique case (sel)
            SEL_CTRL: bus_rdata = ctrl_word(busy);
            SEL_LOW:  bus_rdata = halves.low;
            SEL_HIGH: bus_rdata = halves.high;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cnt_snap_top.sv
module cnt_snap_top
    import cnt_snap_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int LATCH_DLY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    logic [CNT_W-1:0]  live_cnt;
    logic [SNAP_W-1:0] snap;
    logic              busy;
    logic              latch_req;

    cnt_free_runner #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick),
        .cnt  (live_cnt)
    );

    cnt_latch_ctl #(.CNT_W(CNT_W), .LATCH_DLY(LATCH_DLY)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .req      (latch_req),
        .live_cnt (live_cnt),
        .busy     (busy),
        .snap     (snap)
    );

    cnt_reg_port u_port (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .snap      (snap),
        .latch_req (latch_req),
        .bus_rdata (bus_rdata)
    );

    AST_PLAIN_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !latch_req && !busy) |=> (!busy && $stable(snap))); // R9

endmodule

// File: tb/cnt_snap_top_tb_top.sv
module cnt_snap_top_tb_top;

    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_m;
    logic [31:0] rdata_w;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] model_cnt = '0;
    logic [7:0]  model_w = '0;
    bit          tick_run = 0;

    always #4 clk = ~clk;

    cnt_snap_top #(.CNT_W(64), .LATCH_DLY(DLY)) dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m));

    cnt_snap_top #(.CNT_W(8), .LATCH_DLY(DLY)) dut_w (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w));

    always @(posedge clk) begin
        if (rst) begin
            model_cnt <= '0;
            model_w   <= '0;
        end else if (ref_tick) begin
            model_cnt <= model_cnt + 1;
            model_w   <= model_w + 1;
        end
    end

    always @(negedge clk) begin
        if (tick_run) ref_tick <= ($urandom % 4) != 0;
        else ref_tick <= 1'b0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] vm, output logic [31:0] vw);
        @(negedge clk);
        bus_addr = a;
        #1;
        vm = rdata_m;
        vw = rdata_w;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_snap(output logic [63:0] sm, output logic [63:0] sw);
        logic [31:0] hm, hw, lm, lw;
        rd(8'hA8, hm, hw);
        rd(8'hA4, lm, lw);
        sm = {hm, lm};
        sw = {hw, lw};
    endtask

    task automatic do_latch(input bit poke, output logic [63:0] exp_m, output logic [63:0] exp_w);
        int busy_n;
        logic [63:0] sm, sw;
        busy_n = 0;
        exp_m = '0;
        exp_w = '0;
        wr(8'hA0, 32'h2);
        bus_addr = 8'hA0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (rdata_m == 32'h2) begin
                busy_n++;
                exp_m = model_cnt;
                exp_w = {56'h0, model_w};
                if (poke && busy_n == 1) begin
                    bus_wdata = 32'hFFFF_FFFF;
                    bus_wr = 1'b1;
                end
                @(negedge clk);
                bus_wr = 1'b0;
            end else begin
                check("R3 ctrl idle word", {32'h0, rdata_m}, 64'h0);
                break;
            end
        end
        if (poke) check("R7 busy length with extra request", busy_n, DLY);
        else check("R4 busy length", busy_n, DLY);
        read_snap(sm, sw);
        check("R5 R6 snapshot wide", sm, exp_m);
        check("R8 R5 snapshot narrow", sw, exp_w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] vm, vw;
        logic [63:0] em, ew, sm, sw;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(8'hA0, vm, vw);
        check("R1 ctrl after reset", {32'h0, vm}, 64'h0);
        read_snap(sm, sw);
        check("R1 snapshot after reset", sm, 64'h0);
        check("R1 narrow snapshot after reset", sw, 64'h0);

        do_latch(0, em, ew);
        check("R2 count idle without ticks", em, 64'h0);

        tick_run = 1;
        repeat (5) @(negedge clk);
        wr(8'hA0, 32'h2);
        bus_addr = 8'hA0;
        #1;
        check("R3 request bit set", {32'h0, rdata_m}, 64'h2);
        repeat (DLY + 1) @(negedge clk);

        for (int n = 0; n < 40; n++) begin
            do_latch((n % 4) == 1, em, ew);
            repeat ($urandom_range(0, 30)) @(negedge clk);
            read_snap(sm, sw);
            check("R6 snapshot frozen", sm, em);
            check("R6 narrow snapshot frozen", sw, ew);
        end

        do_latch(0, em, ew);
        wr(8'hA4, $urandom);
        wr(8'hA8, $urandom);
        wr(8'hA0, 32'hFFFF_FFFD);
        for (int k = 0; k < DLY + 1; k++) begin
            rd(8'hA0, vm, vw);
            check("R9 ctrl untouched by plain write", {32'h0, vm}, 64'h0);
        end
        read_snap(sm, sw);
        check("R9 snapshot untouched by writes", sm, em);
        check("R9 narrow snapshot untouched", sw, ew);

        tick_run = 0;
        repeat (2) @(negedge clk);
        do_latch(0, em, ew);
        check("R2 final count vs tick model", em, model_cnt);
        check("R8 wrapped narrow count", ew, {56'h0, model_w});

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule